// File: doc/BRIEF.md
# Clock Output Select and Gating Controller

This block sits between the internal clock sources of a multi-output system clock generator and its output drivers. After a power-on reset it samples three configuration straps and a host-speed select, using the reference clock. The strap pins are the same pins that later carry the 48 MHz and reference clocks, so those drivers stay off until the capture is done. From the captured values it decides, for each output, whether it runs, floats or enters a test arrangement. It also chooses the ratio at which the IO clock is divided down from the host clock.

The IO clock is produced by a divider that counts both edges of the host clock. Its rising edges coincide with host rising edges wherever the ratio allows. An active-low power-down input is synchronized separately for every output and gates each output only in that output's idle phase. In power-down the IO, 48 MHz and reference outputs are driven low. The true host output is held high and the complementary host output is released. An active-low spread request is synchronized and forwarded to the host PLL.

Top module: `clk_out_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the straps have been captured, the IO output is low, the true host output is high, the complementary host output is undriven, and neither the 48 MHz nor the reference pins are driven (their drive enables are 0).
- R2: The straps (fast select, strap A, strap B, strap C) are captured on the first reference-clock rising edge after reset is released. Later changes on those inputs have no effect until the next reset. The captured fast select is reported on `host_fast_o`.
- R3: The IO clock period, counted in host clock periods, is 4 for fast=1,C=0; 2 for fast=1,C=1; 3 for fast=0,C=0; and 1.5 for fast=0,C=1.
- R4: For the ratios 4, 2 and 3 the IO clock has a 50% duty cycle and rises only on host rising edges. For the ratio 1.5 it is high for two of every three host half-periods, and its rising edges alternate between host rising and falling edges.
- R5: With A=0,B=0 every 48 MHz output is driven and follows the 48 MHz source. With A=0,B=1 the 48 MHz outputs are undriven.
- R6: With A=1 outside test mode, the 48 MHz and reference outputs are both undriven, while the IO ratio still follows R3.
- R7: The test arrangement fast=1,A=1,B=1,C=0 makes the host output the test clock divided by 2, the 48 MHz and IO outputs the test clock divided by 4, and the reference output the test clock itself.
- R8: Once a low level on `pwrdn_ni` has passed the synchronizers, the IO, 48 MHz and reference outputs are low with their drivers still enabled, the true host output is high and the complementary host output is undriven. After release, all outputs resume.
- R9: Entering or leaving power-down never produces a high or low pulse narrower than that output's normal phase width.
- R10: `spread_req_o` is the inverse of `spread_ni`, delayed by the synchronizer, independent of power-down.
- R11: When its driver is enabled and the block is not powered down, the reference output follows the reference source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk_i | input | 1 | Host clock from the system PLL |
| usb_clk_i | input | 1 | 48 MHz clock from the USB PLL |
| ref_clk_i | input | 1 | Crystal reference clock; also clocks strap capture |
| test_clk_i | input | 1 | Test clock used in the test arrangement |
| rst_ni | input | 1 | Active-low power-on reset |
| fast_sel_i | input | 1 | Host speed select: 1 = 133 MHz, 0 = 100 MHz |
| strap_a_i | input | 1 | Strap A, sampled from a 48 MHz pin |
| strap_b_i | input | 1 | Strap B, sampled from a 48 MHz pin |
| strap_c_i | input | 1 | Strap C, sampled from the reference pin |
| pwrdn_ni | input | 1 | Active-low power-down request (asynchronous) |
| spread_ni | input | 1 | Active-low down-spread request (asynchronous) |
| host_p_o | output | 1 | True host clock output |
| host_n_o | output | 1 | Complementary host clock output |
| host_n_oe_o | output | 1 | Drive enable for the complementary host output |
| io_clk_o | output | 1 | IO clock output |
| usb_clk_o | output | NUM_USB | 48 MHz clock outputs |
| usb_oe_o | output | 1 | Drive enable for the 48 MHz outputs |
| ref_clk_o | output | 1 | Reference clock output |
| ref_oe_o | output | 1 | Drive enable for the reference output |
| host_fast_o | output | 1 | Captured host speed select, sent to the host PLL |
| spread_req_o | output | 1 | Synchronized down-spread request to the host PLL |

## Verification
The bench uses the default parameters: two 48 MHz outputs, two synchronizer stages, and a divider counter sized for a ratio of four. It drives the host, 48 MHz, reference and test sources with distinct periods, so every ratio in R3 and R7 appears as its own period in nanoseconds. The two-stage synchronizers keep the power-down latency short enough that the bench can pulse `pwrdn_ni` for less than the latency of the slowest output. This forces enables to be abandoned part-way through, which is where a runt pulse would appear.

// File: rtl/clk_out_ctrl_pkg.sv
`timescale 1ns/1ps
package clk_out_ctrl_pkg;

    typedef enum logic [1:0] {
        IO_DIV4   = 2'd0,
        IO_DIV2   = 2'd1,
        IO_DIV3   = 2'd2,
        IO_DIV1P5 = 2'd3
    } io_ratio_e;

    // Captured configuration straps
    typedef struct packed {
        logic fast;
        logic a;
        logic b;
        logic c;
    } strap_t;

    // Per-output routing decoded from the straps
    typedef struct packed {
        logic      test;
        logic      usb_off;
        logic      ref_off;
        io_ratio_e ratio;
    } route_t;

    function automatic route_t decode_straps(strap_t s);
        route_t r;
        r.test    = s.fast & s.a & s.b & ~s.c;
        r.usb_off = ~r.test & (s.a | s.b);
        r.ref_off = ~r.test & s.a;
        if (s.fast) r.ratio = s.c ? IO_DIV2 : IO_DIV4;
        else        r.ratio = s.c ? IO_DIV1P5 : IO_DIV3;
        return r;
    endfunction

endpackage

// File: rtl/strap_latch.sv
`timescale 1ns/1ps
module strap_latch
    import clk_out_ctrl_pkg::*;
(
    input  logic   ref_clk_i,
    input  logic   rst_ni,
    input  strap_t straps_i,
    output strap_t straps_o,
    output logic   done_o
);

    typedef struct packed {
        logic   done;
        strap_t val;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.done = 1'b1;
            st_d.val  = straps_i;
        end
    end

    always_ff @(posedge ref_clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign straps_o = st_q.val;
    assign done_o   = st_q.done;

    // R2: once captured, the straps never move until the next reset
    a_r2_straps_frozen: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
        st_q.done |=> (st_q.done && $stable(st_q.val)));

endmodule

// File: rtl/io_divider.sv
`timescale 1ns/1ps
module io_divider
    import clk_out_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_DIV     = 4
) (
    input  logic      host_clk_i,
    input  logic      rst_ni,
    input  logic      go_i,
    input  io_ratio_e ratio_i,
    output logic      io_o
);

    localparam int CNT_W = $clog2(MAX_DIV);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] go;
        logic                   run;
        logic                   warm;
        logic [CNT_W-1:0]       cnt;
        logic                   p;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       n_d, n_q;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] cnt_nxt;

    // Level wanted in the half-period that starts at the given edge
    function automatic logic half_level(io_ratio_e r, logic [CNT_W-1:0] c, logic neg);
        case (r)
            IO_DIV4:   return c < CNT_W'(2);
            IO_DIV2:   return c == CNT_W'(0);
            IO_DIV3:   return neg ? (c == CNT_W'(0)) : (c < CNT_W'(2));
            default:   return neg ? (c != CNT_W'(2)) : (c != CNT_W'(1));
        endcase
    endfunction

    always_comb begin
        case (ratio_i)
            IO_DIV4: last_cnt = CNT_W'(3);
            IO_DIV2: last_cnt = CNT_W'(1);
            default: last_cnt = CNT_W'(2);
        endcase
        if (!st_q.run || st_q.cnt == last_cnt) cnt_nxt = '0;
        else                                   cnt_nxt = st_q.cnt + 1'b1;

        st_d      = st_q;
        st_d.go   = {st_q.go[SYNC_STAGES-2:0], go_i};
        st_d.run  = st_q.go[SYNC_STAGES-1];
        st_d.warm = st_q.run;
        st_d.cnt  = st_q.go[SYNC_STAGES-1] ? cnt_nxt : '0;
        st_d.p    = (st_q.go[SYNC_STAGES-1] ? half_level(ratio_i, cnt_nxt, 1'b0) : 1'b0) ^ n_q;
        n_d       = (st_q.run ? half_level(ratio_i, st_q.cnt, 1'b1) : 1'b0) ^ st_q.p;
    end

    always_ff @(posedge host_clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(negedge host_clk_i or negedge rst_ni) begin
        if (!rst_ni) n_q <= 1'b0;
        else         n_q <= n_d;
    end

    assign io_o = st_q.p ^ n_q;

    // R3: at ratio 2 the level seen at each host rising edge alternates
    a_r3_div2_alternates: assert property (@(posedge host_clk_i) disable iff (!rst_ni)
        (st_q.warm && ratio_i == IO_DIV2) |-> (io_o != $past(io_o)));

    // R4: at ratio 4 a high phase spans at least two host periods
    a_r4_div4_high_two: assert property (@(posedge host_clk_i) disable iff (!rst_ni)
        (st_q.warm && ratio_i == IO_DIV4 && $rose(io_o)) |=> io_o);

endmodule

// File: rtl/clk_gate.sv
`timescale 1ns/1ps
module clk_gate #(
    parameter int SYNC_STAGES = 2,
    parameter bit HOLD_HIGH   = 1'b0
) (
    input  logic src_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic clk_o,
    output logic en_o
);

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   en_d, en_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], run_i};
        en_d   = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge src_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    generate
        if (HOLD_HIGH) begin : g_hold_high
            // idle level is high: switch while the source is high
            always_ff @(posedge src_i or negedge rst_ni) begin
                if (!rst_ni) en_q <= 1'b0;
                else         en_q <= en_d;
            end
            assign clk_o = en_q ? src_i : 1'b1;
        end else begin : g_hold_low
            // idle level is low: switch while the source is low
            always_ff @(negedge src_i or negedge rst_ni) begin
                if (!rst_ni) en_q <= 1'b0;
                else         en_q <= en_d;
            end
            assign clk_o = en_q & src_i;
        end
    endgenerate

    assign en_o = en_q;

endmodule

// File: rtl/clk_out_ctrl.sv
`timescale 1ns/1ps
module clk_out_ctrl
    import clk_out_ctrl_pkg::*;
#(
    parameter int NUM_USB     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_DIV     = 4
) (
    input  logic               host_clk_i,
    input  logic               usb_clk_i,
    input  logic               ref_clk_i,
    input  logic               test_clk_i,
    input  logic               rst_ni,
    input  logic               fast_sel_i,
    input  logic               strap_a_i,
    input  logic               strap_b_i,
    input  logic               strap_c_i,
    input  logic               pwrdn_ni,
    input  logic               spread_ni,
    output logic               host_p_o,
    output logic               host_n_o,
    output logic               host_n_oe_o,
    output logic               io_clk_o,
    output logic [NUM_USB-1:0] usb_clk_o,
    output logic               usb_oe_o,
    output logic               ref_clk_o,
    output logic               ref_oe_o,
    output logic               host_fast_o,
    output logic               spread_req_o
);

    localparam int TDIV_W = 2;

    strap_t pins, cap;
    route_t route;
    logic   cfg_done, run, io_raw;
    logic   host_src, io_src, usb_src, ref_src, host_en;

    logic [TDIV_W-1:0]      tdiv_d, tdiv_q;
    logic [SYNC_STAGES-1:0] spr_d, spr_q;

    assign pins = {fast_sel_i, strap_a_i, strap_b_i, strap_c_i};

    strap_latch u_straps (
        .ref_clk_i (ref_clk_i),
        .rst_ni    (rst_ni),
        .straps_i  (pins),
        .straps_o  (cap),
        .done_o    (cfg_done)
    );

    assign route = decode_straps(cap);

    io_divider #(.SYNC_STAGES(SYNC_STAGES), .MAX_DIV(MAX_DIV)) u_div (
        .host_clk_i (host_clk_i),
        .rst_ni     (rst_ni),
        .go_i       (cfg_done),
        .ratio_i    (route.ratio),
        .io_o       (io_raw)
    );

    // test clock prescaler and spread synchronizer
    always_comb begin
        tdiv_d = tdiv_q + 1'b1;
        spr_d  = {spr_q[SYNC_STAGES-2:0], ~spread_ni};
    end

    always_ff @(posedge test_clk_i or negedge rst_ni) begin
        if (!rst_ni) tdiv_q <= '0;
        else         tdiv_q <= tdiv_d;
    end

    always_ff @(posedge host_clk_i or negedge rst_ni) begin
        if (!rst_ni) spr_q <= '0;
        else         spr_q <= spr_d;
    end

    // sources are selected statically once the straps are captured
    assign host_src = route.test ? tdiv_q[0] : host_clk_i;
    assign io_src   = route.test ? tdiv_q[1] : io_raw;
    assign usb_src  = route.test ? tdiv_q[1] : usb_clk_i;
    assign ref_src  = route.test ? test_clk_i : ref_clk_i;
    assign run      = cfg_done & pwrdn_ni;

    clk_gate #(.SYNC_STAGES(SYNC_STAGES), .HOLD_HIGH(1'b1)) u_gate_host (
        .src_i (host_src), .rst_ni (rst_ni), .run_i (run),
        .clk_o (host_p_o), .en_o (host_en)
    );

    clk_gate #(.SYNC_STAGES(SYNC_STAGES), .HOLD_HIGH(1'b0)) u_gate_io (
        .src_i (io_src), .rst_ni (rst_ni), .run_i (run),
        .clk_o (io_clk_o), .en_o ()
    );

    clk_gate #(.SYNC_STAGES(SYNC_STAGES), .HOLD_HIGH(1'b0)) u_gate_ref (
        .src_i (ref_src), .rst_ni (rst_ni), .run_i (run),
        .clk_o (ref_clk_o), .en_o ()
    );

    for (genvar gi = 0; gi < NUM_USB; gi++) begin : g_usb
        clk_gate #(.SYNC_STAGES(SYNC_STAGES), .HOLD_HIGH(1'b0)) u_gate_usb (
            .src_i (usb_src), .rst_ni (rst_ni), .run_i (run),
            .clk_o (usb_clk_o[gi]), .en_o ()
        );
    end

    assign host_n_o     = host_en & ~host_src;
    assign host_n_oe_o  = host_en;
    assign usb_oe_o     = cfg_done & ~route.usb_off;
    assign ref_oe_o     = cfg_done & ~route.ref_off;
    assign host_fast_o  = cap.fast;
    assign spread_req_o = spr_q[SYNC_STAGES-1];

    // R1: nothing is driven and IO stays low before the straps are in
    a_r1_quiet_before_capture: assert property (@(posedge host_clk_i) disable iff (!rst_ni)
        !cfg_done |-> (!usb_oe_o && !ref_oe_o && !io_clk_o && !host_n_oe_o));

    // R8: whenever the complement is released the true output sits high
    a_r8_host_hold_high: assert property (@(posedge host_clk_i) disable iff (!rst_ni)
        !host_n_oe_o |-> host_p_o);

endmodule

// File: tb/clk_out_ctrl_bench.sv
`timescale 1ns/1ps
module clk_out_ctrl_meter (
    input logic sig,
    input logic clr
);
    realtime t_r, t_f, per, hi, min_hi, min_lo;
    int      rises;

    always @(posedge sig or negedge sig or posedge clr) begin
        if (clr) begin
            t_r = -1.0; t_f = -1.0; per = 0.0; hi = 0.0;
            min_hi = 1.0e9; min_lo = 1.0e9; rises = 0;
        end else if (sig === 1'b1) begin
            if (t_r >= 0.0) per = $realtime - t_r;
            if (t_f >= 0.0 && ($realtime - t_f) < min_lo) min_lo = $realtime - t_f;
            t_r = $realtime;
            rises++;
        end else if (sig === 1'b0) begin
            if (t_r >= 0.0) begin
                hi = $realtime - t_r;
                if (hi < min_hi) min_hi = hi;
            end
            t_f = $realtime;
        end
    end
endmodule

module clk_out_ctrl_bench;

    logic host_clk = 1'b0, usb_src = 1'b0, ref_src = 1'b0, tst_clk = 1'b0;
    logic rst_n = 1'b0, fast = 1'b0, sa = 1'b0, sb = 1'b0, sc = 1'b0;
    logic pwrdn_n = 1'b1, spread_n = 1'b1, clr = 1'b0, align_on = 1'b0;
    logic host_p, host_n, host_n_oe, io_clk, usb_oe, ref_clk, ref_oe, host_fast, spread_req;
    logic [1:0] usb_clk;

    always #2  host_clk = ~host_clk;
    always #10 usb_src  = ~usb_src;
    always #35 ref_src  = ~ref_src;
    always #4  tst_clk  = ~tst_clk;

    clk_out_ctrl u_clk_out_ctrl (
        .host_clk_i (host_clk), .usb_clk_i (usb_src), .ref_clk_i (ref_src),
        .test_clk_i (tst_clk), .rst_ni (rst_n), .fast_sel_i (fast),
        .strap_a_i (sa), .strap_b_i (sb), .strap_c_i (sc),
        .pwrdn_ni (pwrdn_n), .spread_ni (spread_n),
        .host_p_o (host_p), .host_n_o (host_n), .host_n_oe_o (host_n_oe),
        .io_clk_o (io_clk), .usb_clk_o (usb_clk), .usb_oe_o (usb_oe),
        .ref_clk_o (ref_clk), .ref_oe_o (ref_oe),
        .host_fast_o (host_fast), .spread_req_o (spread_req)
    );

    clk_out_ctrl_meter u_m_io  (.sig(io_clk),     .clr(clr));
    clk_out_ctrl_meter u_m_hp  (.sig(host_p),     .clr(clr));
    clk_out_ctrl_meter u_m_u0  (.sig(usb_clk[0]), .clr(clr));
    clk_out_ctrl_meter u_m_u1  (.sig(usb_clk[1]), .clr(clr));
    clk_out_ctrl_meter u_m_ref (.sig(ref_clk),    .clr(clr));

    int misalign = 0;
    always @(posedge io_clk) if (align_on && host_clk !== 1'b1) misalign++;

    // scoreboard
    typedef struct { string tag; longint val; } exp_t;
    exp_t   exp_q[$];
    longint act_q[$];
    event   obs_ev;
    int     vectors = 0, fails = 0;
    bit     finished = 0;

    task automatic chk(input string tag, input longint act, input longint expv);
        exp_t e;
        e.tag = tag; e.val = expv;
        exp_q.push_back(e);
        act_q.push_back(act);
        -> obs_ev;
    endtask

    initial forever begin
        @(obs_ev);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            exp_t   e;
            longint a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            vectors++;
            if (a != e.val) begin
                fails++;
                $display("FAIL %s: actual %0d expected %0d", e.tag, a, e.val);
            end
        end
    end

    function automatic longint ps(input realtime t);
        return longint'(t * 1000.0);
    endfunction

    task automatic restart(input logic f, input logic a, input logic b, input logic c);
        rst_n = 1'b0;
        {fast, sa, sb, sc} = {f, a, b, c};
        #40;
        @(posedge ref_src);
        #1 rst_n = 1'b1;
        #700;
    endtask

    task automatic measure();
        clr = 1'b1;
        #1 clr = 1'b0;
        misalign = 0;
        #500;
    endtask

    initial begin
        // R1: during reset
        #20;
        chk("R1 io in reset", io_clk, 0);
        chk("R1 host_p in reset", host_p, 1);
        chk("R1 host_n_oe in reset", host_n_oe, 0);
        chk("R1 usb_oe in reset", usb_oe, 0);
        chk("R1 ref_oe in reset", ref_oe, 0);

        // R1: after release, before the first capture edge
        {fast, sa, sb, sc} = 4'b1000;
        @(posedge ref_src);
        #1 rst_n = 1'b1;
        #10;
        chk("R1 usb_oe before capture", usb_oe, 0);
        chk("R1 ref_oe before capture", ref_oe, 0);
        chk("R1 io before capture", io_clk, 0);

        // R2: change straps right after the capture edge
        @(posedge ref_src);
        #1 {fast, sb, sc} = 3'b011;
        #700;
        align_on = 1'b1;
        measure();
        chk("R2 R3 io period ratio 4", ps(u_m_io.per), 16000);
        chk("R4 io high ratio 4", ps(u_m_io.hi), 8000);
        chk("R4 io rises on host rise ratio 4", misalign, 0);
        chk("R2 usb_oe frozen", usb_oe, 1);
        chk("R2 host_fast frozen", host_fast, 1);
        chk("R5 usb0 period", ps(u_m_u0.per), 20000);
        chk("R5 usb1 period", ps(u_m_u1.per), 20000);
        chk("R11 ref_oe", ref_oe, 1);
        chk("R11 ref period", ps(u_m_ref.per), 70000);
        chk("R11 host_p period", ps(u_m_hp.per), 4000);

        // R3/R4 ratio 2
        restart(1'b1, 1'b0, 1'b0, 1'b1);
        measure();
        chk("R3 io period ratio 2", ps(u_m_io.per), 8000);
        chk("R4 io high ratio 2", ps(u_m_io.hi), 4000);
        chk("R4 io rises on host rise ratio 2", misalign, 0);

        // R3/R4 ratio 3
        restart(1'b0, 1'b0, 1'b0, 1'b0);
        measure();
        chk("R3 io period ratio 3", ps(u_m_io.per), 12000);
        chk("R4 io high ratio 3", ps(u_m_io.hi), 6000);
        chk("R4 io rises on host rise ratio 3", misalign, 0);
        chk("R2 host_fast low", host_fast, 0);

        // R3/R4 ratio 1.5
        align_on = 1'b0;
        restart(1'b0, 1'b0, 1'b0, 1'b1);
        measure();
        chk("R3 io period ratio 1.5", ps(u_m_io.per), 6000);
        chk("R4 io high ratio 1.5", ps(u_m_io.hi), 4000);

        // R5 usb floating
        restart(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R5 usb_oe with B set", usb_oe, 0);
        chk("R5 ref_oe with B set", ref_oe, 1);

        // R6 debug combination
        restart(1'b0, 1'b1, 1'b0, 1'b0);
        measure();
        chk("R6 usb_oe with A set", usb_oe, 0);
        chk("R6 ref_oe with A set", ref_oe, 0);
        chk("R6 io period with A set", ps(u_m_io.per), 12000);

        // R7 test arrangement
        restart(1'b1, 1'b1, 1'b1, 1'b0);
        measure();
        chk("R7 host period", ps(u_m_hp.per), 16000);
        chk("R7 io period", ps(u_m_io.per), 32000);
        chk("R7 usb period", ps(u_m_u0.per), 32000);
        chk("R7 ref period", ps(u_m_ref.per), 8000);
        chk("R7 usb_oe", usb_oe, 1);

        // R8/R9/R10 power-down and spread
        restart(1'b0, 1'b0, 1'b0, 1'b0);
        clr = 1'b1;
        #1 clr = 1'b0;
        pwrdn_n = 1'b0;
        spread_n = 1'b0;
        #400;
        chk("R8 io low", io_clk, 0);
        chk("R8 usb low", usb_clk, 0);
        chk("R8 usb still driven", usb_oe, 1);
        chk("R8 ref low", ref_clk, 0);
        chk("R8 ref still driven", ref_oe, 1);
        chk("R8 host_p high", host_p, 1);
        chk("R8 host_n released", host_n_oe, 0);
        chk("R10 spread request in power-down", spread_req, 1);
        pwrdn_n = 1'b1;  #137;
        pwrdn_n = 1'b0;  #263;
        pwrdn_n = 1'b1;  #91;
        pwrdn_n = 1'b0;  #411;
        pwrdn_n = 1'b1;  #53;
        pwrdn_n = 1'b0;  #29;
        pwrdn_n = 1'b1;  #700;
        chk("R9 io min high", ps(u_m_io.min_hi) >= 6000, 1);
        chk("R9 io min low", ps(u_m_io.min_lo) >= 6000, 1);
        chk("R9 usb min high", ps(u_m_u0.min_hi) >= 10000, 1);
        chk("R9 usb min low", ps(u_m_u0.min_lo) >= 10000, 1);
        chk("R9 ref min high", ps(u_m_ref.min_hi) >= 35000, 1);
        chk("R9 ref min low", ps(u_m_ref.min_lo) >= 35000, 1);
        chk("R9 host_p min low", ps(u_m_hp.min_lo) >= 2000, 1);
        chk("R8 host_n driven after release", host_n_oe, 1);
        measure();
        chk("R8 io resumes", ps(u_m_io.per), 12000);
        chk("R8 ref resumes", ps(u_m_ref.per), 70000);
        spread_n = 1'b1;
        #20;
        chk("R10 spread request cleared", spread_req, 0);

        #10;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule